// File: doc/BRIEF.md
# Steerable Watchdog Timer

This block is a programmable watchdog timer with a byte-wide register port. Software writes a single configuration byte that holds a five-bit multiplier, a two-bit resolution code and a steering bit. The countdown advances on a tick input that pulses once every sixteenth of a second. The timeout is the multiplier times four raised to the resolution, in ticks. If nothing restarts the countdown before it runs out, the block raises a sticky timeout flag. It then signals the expiry in one of two ways, chosen by the steering bit: a one-cycle interrupt pulse, or a one-cycle reset request.

Software services the watchdog in either of two ways. It can rewrite the configuration byte, which also clears the timeout flag, or it can issue a read strobe to the status byte, which restarts the countdown with the current configuration and leaves the flag as it is. A steered expiry clears the configuration byte and clears one marker bit in an auxiliary byte, so software can tell after the reset that the watchdog caused it. A multiplier of zero disarms the timer.

Top module: `wdt_top`

## Requirements
- R1: After a synchronous active-low reset, the configuration, status and auxiliary bytes read 0x00, `irqPulse` and `rstReq` are low, and the timer is disarmed.
- R2: Address 0 holds the configuration byte: bit 7 is steering, bits [6:2] are the multiplier M and bits [1:0] the resolution R. After a restart, expiry happens on the (M << 2R)-th tick, and the signalling output is high in the cycle after that tick is sampled.
- R3: A write to address 0 stores the byte, reads it back, clears the status flag and restarts the countdown with the new value.
- R4: A read strobe (`rdEn`) to address 1 restarts the countdown with the current configuration and leaves the status flag unchanged.
- R5: Expiry sets bit 7 of the status byte at address 1. The other status bits read 0.
- R6: With the steering bit set at expiry, `rstReq` pulses for exactly one cycle, `irqPulse` stays low, the configuration byte becomes 0x00 and bit 6 of the auxiliary byte is cleared. The other auxiliary bits are kept.
- R7: With the steering bit clear at expiry, `irqPulse` pulses for exactly one cycle, `rstReq` stays low and the configuration and auxiliary bytes are unchanged.
- R8: Writes to address 1 are ignored: the status byte keeps its value.
- R9: A restart with a multiplier of zero disarms the timer, so no expiry occurs however many ticks arrive.
- R10: After an expiry the countdown halts. No further expiry occurs until the next restart.
- R11: A restart in the same cycle as the final tick wins: no expiry occurs, and the new countdown starts in full.
- R12: Address 2 is a freely readable and writable auxiliary byte. If a write to it coincides with a steered expiry, the written value is kept. Address 3 reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle pulse every 1/16 second |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe (matters only at address 1) |
| addr | input | 2 | Register address |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for `addr`, combinational |
| irqPulse | output | 1 | One-cycle interrupt on unsteered expiry |
| rstReq | output | 1 | One-cycle reset request on steered expiry |

## Verification
The bench targets off-by-one tick counts at every resolution code. A design that miscounts would fire one tick early or late, or would scale by 2^R instead of 4^R. It checks that reading status restarts without clearing the flag, that a status write is ignored, and that a zero multiplier disarms the timer. A design that got these wrong would clear the flag, corrupt it, or fire immediately. The steered path is checked for the cleared configuration, the single cleared auxiliary bit and a reset request that is one cycle wide. The bench also checks that the countdown halts after expiry and that a restart landing on the final tick suppresses the expiry. A design that got these wrong would raise repeated interrupts or a spurious event.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam logic [1:0] ADDR_CFG  = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_AUX  = 2'd2;

  typedef struct packed {
    logic cfgWr;
    logic auxWr;
    logic restart;
    logic countDn;
    logic expire;
    logic steerHit;
  } wdtStrobes_t;
endpackage

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        tick,
  input  logic        wrEn,
  input  logic        rdEn,
  input  logic [1:0]  addr,
  input  logic        lastTick,
  input  logic        steer,
  output wdtStrobes_t stb,
  output logic        irqPulse,
  output logic        rstReq
);
  always_comb begin
    stb.cfgWr    = wrEn && (addr == ADDR_CFG);
    stb.auxWr    = wrEn && (addr == ADDR_AUX);
    stb.restart  = stb.cfgWr || (rdEn && (addr == ADDR_STAT));
    stb.countDn  = tick && !stb.restart;
    stb.expire   = stb.countDn && lastTick;
    stb.steerHit = stb.expire && steer;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqPulse <= 1'b0;
      rstReq   <= 1'b0;
    end else begin
      irqPulse <= stb.expire && !steer;
      rstReq   <= stb.steerHit;
    end
  end

  // R6 R7
  event_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(irqPulse && rstReq));
  // R7
  irq_one_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |=> !irqPulse);
  // R6
  rst_one_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |=> !rstReq);
endmodule

// File: rtl/wdt_datapath.sv
module wdt_datapath
  import wdt_pkg::*;
#(
  parameter int DW        = 8,
  parameter int MULT_W    = 5,
  parameter int RES_W     = 2,
  parameter int AUX_CLR_B = 6
) (
  input  logic          clk,
  input  logic          rstN,
  input  wdtStrobes_t   stb,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] wrData,
  output logic [DW-1:0] rdData,
  output logic          lastTick,
  output logic          steer
);
  localparam int MAX_SHIFT = 2 * ((1 << RES_W) - 1);
  localparam int CNT_W     = MULT_W + MAX_SHIFT;

  logic [DW-1:0]     cfgReg, auxReg;
  logic              flagReg, running;
  logic [CNT_W-1:0]  cnt;
  logic [DW-1:0]     loadSrc;
  logic [MULT_W-1:0] loadMult;
  logic [RES_W-1:0]  loadRes;
  logic [CNT_W-1:0]  loadCnt;

  always_comb begin
    loadSrc  = stb.cfgWr ? wrData : cfgReg;
    loadMult = loadSrc[RES_W +: MULT_W];
    loadRes  = loadSrc[RES_W-1:0];
    loadCnt  = CNT_W'(loadMult) << (2 * loadRes);
  end

  assign lastTick = running && (cnt == CNT_W'(1));
  assign steer    = cfgReg[DW-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt     <= '0;
      running <= 1'b0;
    end else if (stb.restart) begin
      cnt     <= loadCnt;
      running <= (loadMult != '0);
    end else if (stb.countDn && running) begin
      cnt <= cnt - CNT_W'(1);
      if (cnt == CNT_W'(1)) running <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgReg  <= '0;
      flagReg <= 1'b0;
    end else begin
      if (stb.cfgWr)         cfgReg <= wrData;
      else if (stb.steerHit) cfgReg <= '0;
      if (stb.cfgWr)         flagReg <= 1'b0;
      else if (stb.expire)   flagReg <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)             auxReg <= '0;
    else if (stb.auxWr)    auxReg <= wrData;
    else if (stb.steerHit) auxReg[AUX_CLR_B] <= 1'b0;
  end

  always_comb begin
    unique case (addr)
      ADDR_CFG:  rdData = cfgReg;
      ADDR_STAT: rdData = {flagReg, {(DW-1){1'b0}}};
      ADDR_AUX:  rdData = auxReg;
      default:   rdData = '0;
    endcase
  end

  // R3
  cfg_wr_clears_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.cfgWr |=> !flagReg);
  // R5
  expire_sets_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.expire |=> flagReg);
  // R6
  steer_clears_cfg_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.steerHit |=> (cfgReg == '0));
  // R9
  zero_mult_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.restart && loadMult == '0) |=> !running);
  // R10
  halt_after_expire_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.expire |=> !running);
endmodule

// File: rtl/wdt_top.sv
module wdt_top
  import wdt_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       wrEn,
  input  logic       rdEn,
  input  logic [1:0] addr,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  output logic       irqPulse,
  output logic       rstReq
);
  wdtStrobes_t stb;
  logic lastTick, steer;

  wdt_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .tick(tick), .wrEn(wrEn), .rdEn(rdEn),
    .addr(addr), .lastTick(lastTick), .steer(steer), .stb(stb),
    .irqPulse(irqPulse), .rstReq(rstReq)
  );

  wdt_datapath #(.DW(8), .MULT_W(5), .RES_W(2), .AUX_CLR_B(6)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .addr(addr), .wrData(wrData),
    .rdData(rdData), .lastTick(lastTick), .steer(steer)
  );
endmodule

// File: tb/sim_wdt_top.sv
module sim_wdt_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tick = 1'b0, wrEn = 1'b0, rdEn = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wrData = 8'd0;
  logic [7:0] rdData;
  logic irqPulse, rstReq;

  always #4 clk = ~clk;

  wdt_top u0 (.clk(clk), .rstN(rstN), .tick(tick), .wrEn(wrEn), .rdEn(rdEn),
              .addr(addr), .wrData(wrData), .rdData(rdData),
              .irqPulse(irqPulse), .rstReq(rstReq));

  int checks = 0, fails = 0;
  bit done = 1'b0;

  // behavioural reference model
  logic [7:0] mCfg, mAux;
  bit mFlag, mRun, mIrq, mRst;
  int mRemain;

  task automatic mStart(input logic [7:0] c);
    mRemain = (1 << (2 * c[1:0])) * c[6:2];
    mRun = (mRemain != 0);
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      mCfg = 0; mAux = 0; mFlag = 0; mRun = 0; mIrq = 0; mRst = 0; mRemain = 0;
    end else begin
      mIrq = 0; mRst = 0;
      if (wrEn && addr == 2'd0) begin
        mCfg = wrData; mFlag = 0; mStart(mCfg);
      end else if (rdEn && addr == 2'd1) begin
        mStart(mCfg);
      end else if (tick && mRun) begin
        mRemain = mRemain - 1;
        if (mRemain == 0) begin
          mRun = 0; mFlag = 1;
          if (mCfg[7]) begin mCfg = 0; mAux[6] = 1'b0; mRst = 1; end
          else mIrq = 1;
        end
      end
      if (wrEn && addr == 2'd2) mAux = wrData;
    end
  end

  function automatic logic [7:0] mRead(input logic [1:0] a);
    case (a)
      2'd0: return mCfg;
      2'd1: return {mFlag, 7'd0};
      2'd2: return mAux;
      default: return 8'd0;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  logic lastIrq, lastRst;
  logic [7:0] lastData;

  task automatic step(input logic w, input logic r, input logic [1:0] a,
                      input logic [7:0] d, input logic t);
    @(negedge clk);
    lastIrq = irqPulse; lastRst = rstReq; lastData = rdData;
    if (rstN) begin
      chk(irqPulse == mIrq, "R7 irqPulse vs model", irqPulse, mIrq);
      chk(rstReq == mRst, "R6 rstReq vs model", rstReq, mRst);
      chk(rdData == mRead(addr), "R2 rdData vs model", rdData, mRead(addr));
    end
    wrEn = w; rdEn = r; addr = a; wrData = d; tick = t;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 2'd1, 8'd0, logic'(i % 2));
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] v);
    step(0, 0, a, 8'd0, 0);
    step(0, 0, a, 8'd0, 0);
    v = lastData;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    step(1, 0, a, d, 0);
    step(0, 0, a, 8'd0, 0);
  endtask

  task automatic waitEvent(input int limit, output int ticks);
    ticks = 0;
    for (int i = 0; i < limit; i++) begin
      logic t;
      t = logic'(i % 2);
      step(0, 0, 2'd1, 8'd0, t);
      if (lastIrq || lastRst) break;
      ticks += int'(t);
    end
  endtask

  initial begin
    logic [7:0] v;
    int n;
    step(0, 0, 2'd0, 8'd0, 0);
    step(0, 0, 2'd0, 8'd0, 0);
    rstN = 1'b1;
    // R1 reset state
    peek(2'd0, v); chk(v == 8'h00, "R1 cfg after reset", v, 0);
    peek(2'd1, v); chk(v == 8'h00, "R1 status after reset", v, 0);
    peek(2'd2, v); chk(v == 8'h00, "R1 aux after reset", v, 0);
    chk(!lastIrq && !lastRst, "R1 outputs low", {lastIrq, lastRst}, 0);
    idle(40);

    // R2 R7: M=3 R=0 -> 3 ticks, interrupt
    wr(2'd0, 8'h0C);
    peek(2'd0, v); chk(v == 8'h0C, "R3 cfg readback", v, 8'h0C);
    waitEvent(200, n);
    chk(n == 3, "R2 ticks M3 R0", n, 3);
    chk(lastIrq && !lastRst, "R7 irq not reset", {lastIrq, lastRst}, 2'b10);
    peek(2'd0, v); chk(v == 8'h0C, "R7 cfg kept", v, 8'h0C);
    peek(2'd1, v); chk(v == 8'h80, "R5 flag set", v, 8'h80);

    // R10: halted after expiry
    waitEvent(100, n); chk(n == 50, "R10 no repeat event", n, 50);

    // R8: status write ignored
    wr(2'd1, 8'h00);
    peek(2'd1, v); chk(v == 8'h80, "R8 status write ignored", v, 8'h80);

    // R2: M=2 R=1 -> 8 ticks; R3 flag cleared by write
    wr(2'd0, 8'h09);
    peek(2'd1, v); chk(v == 8'h00, "R3 flag cleared", v, 0);
    waitEvent(200, n); chk(n == 8, "R2 ticks M2 R1", n, 8);

    // R2: M=1 R=3 -> 64 ticks
    wr(2'd0, 8'h07);
    waitEvent(400, n); chk(n == 64, "R2 ticks M1 R3", n, 64);

    // R4: read restart, flag kept
    wr(2'd0, 8'h10);
    for (int i = 0; i < 6; i++) step(0, 0, 2'd1, 8'd0, logic'(i % 2));
    step(0, 1, 2'd1, 8'd0, 0);
    waitEvent(200, n); chk(n == 4, "R4 read restarts full count", n, 4);
    step(0, 1, 2'd1, 8'd0, 0);
    step(0, 0, 2'd1, 8'd0, 0);
    chk(lastData == 8'h80, "R4 read keeps flag", lastData, 8'h80);

    // R9: zero multiplier
    wr(2'd0, 8'h03);
    waitEvent(200, n); chk(n == 100, "R9 zero mult no expiry", n, 100);

    // R11: restart on final tick
    wr(2'd0, 8'h04);
    step(1, 0, 2'd0, 8'h04, 1);
    step(0, 0, 2'd1, 8'd0, 0);
    chk(!lastIrq && !lastRst, "R11 restart wins", {lastIrq, lastRst}, 0);
    step(0, 0, 2'd1, 8'd0, 0);
    chk(!lastIrq, "R11 no late event", lastIrq, 0);
    waitEvent(50, n); chk(n == 1, "R11 full count after restart", n, 1);

    // R6: steered expiry
    wr(2'd2, 8'h7F);
    wr(2'd0, 8'h84);
    waitEvent(50, n);
    chk(n == 1, "R6 ticks steered", n, 1);
    chk(lastRst && !lastIrq, "R6 reset not irq", {lastIrq, lastRst}, 2'b01);
    step(0, 0, 2'd1, 8'd0, 0);
    chk(!lastRst, "R6 reset one cycle", lastRst, 0);
    peek(2'd0, v); chk(v == 8'h00, "R6 cfg cleared", v, 0);
    peek(2'd2, v); chk(v == 8'h3F, "R6 aux bit6 cleared", v, 8'h3F);
    peek(2'd1, v); chk(v == 8'h80, "R5 flag after steer", v, 8'h80);
    idle(30);

    // R12: aux write wins over steered clear; addr 3
    wr(2'd2, 8'h40);
    wr(2'd0, 8'h84);
    step(1, 0, 2'd2, 8'h55, 1);
    step(0, 0, 2'd2, 8'd0, 0);
    chk(lastRst, "R12 steered expiry happened", lastRst, 1);
    peek(2'd2, v); chk(v == 8'h55, "R12 aux write wins", v, 8'h55);
    wr(2'd3, 8'hFF);
    peek(2'd3, v); chk(v == 8'h00, "R12 addr3 reads zero", v, 0);
    wr(2'd2, 8'hA5);
    peek(2'd2, v); chk(v == 8'hA5, "R12 aux readback", v, 8'hA5);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule